// File: doc/BRIEF.md
# Serial Line Transmitter with Break Insertion

This block turns bytes into asynchronous serial frames on a single output line. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts exactly one interval of an externally supplied baud tick, and the line sits high when idle. Bytes arrive on a valid/ready stream. A one-byte holding stage sits in front of a shift stage, so a second byte can wait while the first is on the line. A byte that is waiting when a stop bit ends starts on that same tick, with no idle gap.

A level-sensitive break request pulls the line low for as long as it stays high. The break is ordered against queued data. It does not begin until the shift stage and the holding stage are both empty, so every byte accepted before the break goes out whole. A byte accepted while the break is active stays in the holding stage until the request drops. After the request drops, the line returns high for at least one full bit interval before that byte's start bit.

Back-pressure is simple: `in_ready` is high exactly when the holding stage is empty. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. The source must keep `in_valid` and `in_data` steady until that edge. While `in_ready` is low, `in_valid` has no effect.

Top module: `uart_brk_tx`

## Requirements
- R1: During and immediately after reset, `tx` is 1, `in_ready` is 1 and no break is active.
- R2: A byte in the holding stage starts on a rising edge where `baud_tick` is 1. From the next cycle `tx` carries 0 (start), then data bit 0 through bit 7, then 1 (stop), one bit per tick interval, and changes only on tick edges.
- R3: `in_ready` goes to 0 in the cycle after a transfer, and goes back to 1 only in the cycle after the byte moves into the shift stage.
- R4: When a byte is waiting as a stop bit ends, its start bit begins on the tick that ends the stop bit. Start edges of consecutive frames are therefore 10 tick intervals apart.
- R5: Once a break has begun, `tx` stays 0 in every cycle until `brk_req` returns to 0.
- R6: With `brk_req` at 1, `tx` is not held low for a break until the byte in the shift stage and the byte in the holding stage have both been sent in full, stop bit included. This also holds when the request rises in the very cycle a byte moves into the shift stage.
- R7: A byte accepted while a break is active is not sent during the break. `in_ready` stays 0 until that byte is transmitted after release.
- R8: After `brk_req` falls during a break, `tx` goes to 1 in the next cycle. The held byte's start bit begins on the second tick after release, so the line is high for at least one full tick interval first.
- R9: If `brk_req` drops again before the queued data has drained, no break is produced and the line stays high after the last frame.
- R10: `in_valid` asserted while `in_ready` is 0 does not change the waiting byte; the byte sent is the one accepted earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | 8 | Byte offered by the source |
| in_ready | output | 1 | Holding stage empty; a transfer may occur |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| brk_req | input | 1 | Level request to hold the line low |
| tx | output | 1 | Serial output, idles high |

## Verification
Two events can land on the same edge: a held byte moving into the shift stage on a tick, and the break request rising. The bench waits for a byte to be accepted and then for the negative edge just before the next tick. It raises `brk_req` there, so the request and the load are sampled together. The result is judged by decoding the whole frame at mid-bit points and confirming the byte is intact. The line must then be low one tick interval after the stop bit. The exit tick of the post-break high interval is also the edge that loads the held byte. The bench judges that case by measuring the release-to-start distance against one full interval.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  // break sequencer states
  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,  // normal traffic
    BK_DRAIN = 2'd1,  // request seen, queued bytes still going out
    BK_LOW   = 2'd2,  // line forced low
    BK_MARK  = 2'd3   // line high after release, loads blocked
  } brk_st_e;

  // serial frame = start + data + stop
  function automatic int frame_len(input int data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] q
);

  logic accept;

  assign wr_ready = !full;
  assign accept   = wr_valid && !full;

  // take only happens while full, accept only while empty: never together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else begin
      if (take) begin
        full <= 1'b0;
      end
      if (accept) begin
        full <= 1'b1;
        q    <= wr_data;
      end
    end
  end

endmodule

// File: rtl/uart_brk_shifter.sv
module uart_brk_shifter
  import uart_brk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] start_data,
  output logic          busy,
  output logic          last,
  output logic          line
);

  localparam int FW = frame_len(DW);
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] frame;
  logic [CW-1:0] cnt;

  // last: the coming tick closes the stop bit
  assign last = busy && (cnt == CW'(1));
  assign line = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '1;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      frame <= {1'b1, start_data, 1'b0};
      cnt   <= CW'(FW);
      busy  <= 1'b1;
    end else if (tick && busy) begin
      frame <= {1'b1, frame[FW-1:1]};
      cnt   <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_brk_seq.sv
module uart_brk_seq
  import uart_brk_pkg::*;
#(
  parameter int MARK_TICKS = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    tick,
  input  logic    shift_busy,
  input  logic    hold_full,
  output brk_st_e st,
  output logic    load_ok,
  output logic    line_low
);

  brk_st_e st_nx;
  logic    mark_done;

  generate
    if (MARK_TICKS <= 1) begin : g_mark_one
      assign mark_done = tick;
    end else begin : g_mark_cnt
      localparam int MW = $clog2(MARK_TICKS);
      logic [MW-1:0] mcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mcnt <= '0;
        end else if (st != BK_MARK) begin
          mcnt <= '0;
        end else if (tick) begin
          mcnt <= mcnt + MW'(1);
        end
      end
      assign mark_done = tick && (mcnt == MW'(MARK_TICKS - 1));
    end
  endgenerate

  always_comb begin
    st_nx = st;
    unique case (st)
      BK_IDLE:  if (req) st_nx = BK_DRAIN;
      BK_DRAIN: begin
        if (!req) begin
          st_nx = BK_IDLE;
        end else if (!shift_busy && !hold_full) begin
          st_nx = BK_LOW;
        end
      end
      BK_LOW:   if (!req) st_nx = BK_MARK;
      BK_MARK:  if (mark_done) st_nx = BK_IDLE;
      default:  st_nx = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= BK_IDLE;
    end else begin
      st <= st_nx;
    end
  end

  // the tick that ends the high interval may also start the held byte
  assign load_ok  = (st == BK_IDLE) || (st == BK_DRAIN) ||
                    ((st == BK_MARK) && mark_done);
  assign line_low = (st == BK_LOW);

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MARK_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          baud_tick,
  input  logic          brk_req,
  output logic          tx
);

  logic          hold_full;
  logic [DW-1:0] hold_q;
  logic          sh_busy;
  logic          sh_last;
  logic          sh_line;
  logic          load_go;
  logic          load_ok;
  logic          brk_low;
  brk_st_e       brk_st;

  // move the waiting byte on a tick when the shifter is free or finishing
  assign load_go = baud_tick && hold_full && load_ok && (!sh_busy || sh_last);

  uart_brk_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_data  (in_data),
    .wr_ready (in_ready),
    .take     (load_go),
    .full     (hold_full),
    .q        (hold_q)
  );

  uart_brk_shifter #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .start      (load_go),
    .start_data (hold_q),
    .busy       (sh_busy),
    .last       (sh_last),
    .line       (sh_line)
  );

  uart_brk_seq #(.MARK_TICKS(MARK_TICKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (brk_req),
    .tick       (baud_tick),
    .shift_busy (sh_busy),
    .hold_full  (hold_full),
    .st         (brk_st),
    .load_ok    (load_ok),
    .line_low   (brk_low)
  );

  assign tx = brk_low ? 1'b0 : sh_line;

endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          baud_tick,
  input logic          tx,
  input logic          load,
  input logic          busy,
  input logic          in_break,
  input logic [DW-1:0] hold_q
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (tx && in_ready && !in_break));

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(tx));

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(load));

  // R5
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !tx);

  // R6
  break_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !busy);

  // R7
  no_load_in_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !load);

  // R8
  release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_break) |-> tx);

  // R10
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !load) |=> $stable(hold_q));

endmodule

bind uart_brk_tx uart_brk_tx_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .baud_tick (baud_tick),
  .tx        (tx),
  .load      (load_go),
  .busy      (sh_busy),
  .in_break  (brk_low),
  .hold_q    (hold_q)
);

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;

  localparam int TP = 8;   // clock cycles per bit interval
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       brk_req = 1'b0;
  logic       baud_tick;
  logic       in_ready;
  logic       tx;

  int    tcnt = 0;
  longint cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt == TP - 1) ? 0 : tcnt + 1;
    cyc  <= cyc + 1;
  end
  assign baud_tick = (tcnt == TP - 1);

  uart_brk_tx uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .baud_tick (baud_tick),
    .brk_req   (brk_req),
    .tx        (tx)
  );

  function automatic logic [9:0] frm(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // decode one frame at mid-bit points; t0 = cycle count when start seen
  task automatic rx_frame(output logic [9:0] f, output longint t0);
    @(negedge clk);
    while (tx !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (TP / 2) @(negedge clk);
    f[0] = tx;
    for (int b = 1; b < 10; b++) begin
      repeat (TP) @(negedge clk);
      f[b] = tx;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] fa, fb;
    longint ta, tb, trel;
    bit all_ok;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tx === 1'b1 && in_ready === 1'b1, "R1 in reset", {tx, in_ready}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx === 1'b1 && in_ready === 1'b1, "R1 after reset", {tx, in_ready}, 2'b11);

    // table walk: R2 frame shape, R3 ready handshake
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      chk(in_ready === 1'b0, "R3 ready low after transfer", in_ready, 0);
      rx_frame(fa, ta);
      chk(fa === frm(VEC[i]), "R2 frame", fa, frm(VEC[i]));
      chk(in_ready === 1'b1, "R3 ready back after load", in_ready, 1);
    end

    // R4: back-to-back frames
    fork
      begin send(8'h3C); send(8'hC3); end
      begin rx_frame(fa, ta); rx_frame(fb, tb); end
    join
    chk(fa === frm(8'h3C), "R4 first frame", fa, frm(8'h3C));
    chk(fb === frm(8'hC3), "R4 second frame", fb, frm(8'hC3));
    chk((tb - ta) == 10 * TP, "R4 start spacing", 32'(tb - ta), 10 * TP);

    // R6: break waits for both stages to drain
    repeat (2 * TP) @(negedge clk);
    fork
      begin send(8'h96); send(8'h69); brk_req = 1'b1; end
      begin rx_frame(fa, ta); rx_frame(fb, tb); end
    join
    chk(fa === frm(8'h96), "R6 shift byte intact", fa, frm(8'h96));
    chk(fb === frm(8'h69), "R6 held byte intact", fb, frm(8'h69));
    repeat (TP) @(negedge clk);
    chk(tx === 1'b0, "R5 break started", tx, 0);
    all_ok = 1'b1;
    for (int k = 0; k < 5 * TP; k++) begin
      @(negedge clk);
      if (tx !== 1'b0) all_ok = 1'b0;
    end
    chk(all_ok, "R5 line low throughout", all_ok, 1);

    // R7: byte written during break is held; R10: extra offer ignored
    send(8'hE7);
    chk(in_ready === 1'b0, "R7 ready low during break", in_ready, 0);
    in_valid = 1'b1;
    in_data  = 8'h18;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    all_ok = 1'b1;
    for (int k = 0; k < 3 * TP; k++) begin
      @(negedge clk);
      if (tx !== 1'b0 || in_ready !== 1'b0) all_ok = 1'b0;
    end
    chk(all_ok, "R7 byte held while break", all_ok, 1);

    // R8: release, high interval, then held byte
    brk_req = 1'b0;
    trel = cyc;
    @(negedge clk);
    chk(tx === 1'b1, "R8 line high after release", tx, 1);
    rx_frame(fa, ta);
    chk((ta - trel) >= TP, "R8 high for a full interval", 32'(ta - trel), TP);
    chk(fa === frm(8'hE7), "R10 held byte sent unchanged", fa, frm(8'hE7));

    // R9: request withdrawn before drain completes
    fork
      begin
        send(8'h4B);
        repeat (2 * TP) @(negedge clk);
        brk_req = 1'b1;
        repeat (TP) @(negedge clk);
        brk_req = 1'b0;
      end
      begin rx_frame(fa, ta); end
    join
    chk(fa === frm(8'h4B), "R9 frame intact", fa, frm(8'h4B));
    all_ok = 1'b1;
    for (int k = 0; k < 3 * TP; k++) begin
      @(negedge clk);
      if (tx !== 1'b1) all_ok = 1'b0;
    end
    chk(all_ok, "R9 no break produced", all_ok, 1);

    // R6 corner: request rises in the cycle the byte is loaded
    fork
      begin
        send(8'hD2);
        while (!baud_tick) @(negedge clk);
        brk_req = 1'b1;
      end
      begin rx_frame(fa, ta); end
    join
    chk(fa === frm(8'hD2), "R6 same-cycle load frame intact", fa, frm(8'hD2));
    repeat (TP) @(negedge clk);
    chk(tx === 1'b0, "R5 break after same-cycle load", tx, 0);
    brk_req = 1'b0;
    repeat (4 * TP) @(negedge clk);
    chk(tx === 1'b1 && in_ready === 1'b1, "R8 idle after release", {tx, in_ready}, 2'b11);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule